// File: doc/BRIEF.md
# Strobe-Synchronised Parallel Port Endpoint

This block sits on the device side of a handshaked 8-bit parallel port. A slow host drives the port. The block runs from a fast system clock. It passes the host's asynchronous strobe, its control line and the eight data pins through two-flop synchronisers. It then finds edges on the synchronised copies and uses them to move bytes.

In the receive direction, the block latches each byte the host writes and offers it on a valid/ready output stream. In the transmit direction, it takes bytes from a valid/ready input stream and holds each one on the data pins for the host to read.

Two timing schemes set when a byte counts as moved:
- **Strobe scheme.** This is the port's own strobe. It is usable when the host spaces its accesses three E cycles apart, which gives roughly 236 to 239 KB/s.
- **Control-line scheme.** The host flips a spare control line once per byte, using bit-set and bit-clear writes.

For transmit under the strobe scheme, the host opens a burst with one dummy read. That read only serves to produce the first strobe.

Top module: `pport_endpoint`

## Requirements
- R1: While reset is asserted and just after it is released, `rx_valid`, `rx_overflow`, `tx_ready` and `port_data_oe` are all 0.
- R2: With `cfg_tx`=0 (receive) and `cfg_ctl_clk`=0 (strobe scheme), the byte on `port_data_in` at a falling edge of the active-low `port_stb_n` is delivered on `rx_data`. Every byte of a burst with three-E-cycle spacing comes out once, in the order written.
- R3: In receive with the strobe scheme, neither a change on `port_data_in` nor a rising edge of `port_stb_n` produces a byte unless a falling edge also occurs.
- R4: With `cfg_ctl_clk`=1 (control-line scheme) in receive, every change of level on `port_ctl` (rising or falling) delivers the byte then on `port_data_in`. Pulses on `port_stb_n` deliver nothing.
- R5: A byte that arrives while `rx_valid`=1 and `rx_ready`=0 is dropped. `rx_overflow` pulses high for one clock, and the held byte stays unchanged. A byte that arrives in the very clock in which the held byte is accepted is taken with no overflow.
- R6: In transmit (`cfg_tx`=1) with the strobe scheme, one byte is placed on the pins as soon as it is offered. Each later byte replaces it only on a rising edge of `port_stb_n`. After one dummy read, the host's n-th real read, taken every three E cycles, returns the n-th byte.
- R7: In transmit with the control-line scheme, the first byte is on the pins before any host event. Each level change of `port_ctl` advances to the next byte, so the host's first read already returns the first byte.
- R8: `port_data_oe` is 1 exactly while the active direction is transmit. In transmit, host strobes and control-line changes deliver nothing on the receive stream.
- R9: A change on `cfg_tx` or `cfg_ctl_clk` takes effect only while the block is idle, that is, while no received byte is held and no transmit byte is waiting on the pins.
- R10: If the input stream is empty at an advancing event, the pins keep the last byte. The next offered byte is placed on the pins without waiting for a host event.
- R11: A byte taken from the input stream (`tx_valid`=1 and `tx_ready`=1 at a clock edge) is on `port_data_out` from that edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ctl_clk | input | 1 | Timing scheme: 0 strobe, 1 control-line clock |
| cfg_tx | input | 1 | Direction: 0 receive, 1 transmit |
| port_stb_n | input | 1 | Host strobe, active low, asynchronous |
| port_ctl | input | 1 | Host-toggled control line, asynchronous |
| port_data_in | input | 8 | Data pins as driven by the host |
| port_data_out | output | 8 | Data presented to the host |
| port_data_oe | output | 1 | Drive enable for the data pins |
| rx_valid | output | 1 | Received byte available |
| rx_data | output | 8 | Received byte |
| rx_ready | input | 1 | Downstream accepts the received byte |
| rx_overflow | output | 1 | One-clock pulse per dropped byte |
| tx_valid | input | 1 | Byte offered for transmit |
| tx_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Offered byte is taken this clock |

## Verification
Two receive functions can land in the same clock: capturing a new byte, and the downstream accepting the byte already held. The bench provokes this by holding `rx_ready` low so that one byte stays held. It then drops the strobe for a second byte and raises `rx_ready` for exactly the one clock in which the synchronised falling edge is acted upon. That clock is counted as the third rising edge after the pin change. The case is judged correct when the scoreboard sees both bytes in order and the overflow counter does not move.

// File: rtl/pport_pkg.sv
`timescale 1ns/1ps
package pport_pkg;

  typedef enum logic {
    SYNC_STROBE = 1'b0,
    SYNC_CTLCLK = 1'b1
  } sync_mode_e;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_ANY  = 2'd2
  } edge_kind_e;

  // chooses the event that counts for the active timing scheme
  function automatic logic sel_event(sync_mode_e mode, logic strobe_evt, logic ctl_evt);
    return (mode == SYNC_CTLCLK) ? ctl_evt : strobe_evt;
  endfunction

  // receive holding register can take a byte
  function automatic logic rx_room(logic held, logic ready);
    return !held || ready;
  endfunction

  // transmit slot takes a byte: on an advance, or to refill an empty slot
  function automatic logic tx_take(logic offered, logic advance, logic full);
    return offered && (advance || !full);
  endfunction

endpackage

// File: rtl/pport_sync.sv
`timescale 1ns/1ps
module pport_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[g] <= RST_VAL;
      else        stg[g] <= stg[g-1];
    end
  end

  assign q = stg[LAST];
endmodule

// File: rtl/pport_edge.sv
`timescale 1ns/1ps
module pport_edge #(
  parameter pport_pkg::edge_kind_e KIND = pport_pkg::EDGE_FALL,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic evt
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= sig;
  end

  if (KIND == pport_pkg::EDGE_FALL) begin : g_fall
    assign evt = prev & ~sig;
  end else if (KIND == pport_pkg::EDGE_RISE) begin : g_rise
    assign evt = ~prev & sig;
  end else begin : g_any
    assign evt = prev ^ sig;
  end
endmodule

// File: rtl/pport_rx.sv
`timescale 1ns/1ps
module pport_rx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] din,
  input  logic          rx_ready,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  output logic          overflow
);
  logic take_w;
  logic drop_w;

  assign take_w = cap && pport_pkg::rx_room(rx_valid, rx_ready);
  assign drop_w = cap && !pport_pkg::rx_room(rx_valid, rx_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      overflow <= 1'b0;
    end else begin
      overflow <= drop_w;
      if (take_w) begin
        rx_valid <= 1'b1;
        rx_data  <= din;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pport_tx.sv
`timescale 1ns/1ps
module pport_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          adv,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ready,
  output logic [DW-1:0] pins,
  output logic          slot_full
);
  assign tx_ready = en && pport_pkg::tx_take(tx_valid, adv, slot_full);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pins      <= '0;
      slot_full <= 1'b0;
    end else if (tx_ready) begin
      pins      <= tx_data;
      slot_full <= 1'b1;
    end else if (adv) begin
      slot_full <= 1'b0;
    end
  end
endmodule

// File: rtl/pport_endpoint.sv
`timescale 1ns/1ps
module pport_endpoint #(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_ctl_clk,
  input  logic          cfg_tx,
  input  logic          port_stb_n,
  input  logic          port_ctl,
  input  logic [DW-1:0] port_data_in,
  output logic [DW-1:0] port_data_out,
  output logic          port_data_oe,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  input  logic          rx_ready,
  output logic          rx_overflow,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ready
);
  import pport_pkg::*;

  logic          stb_s;
  logic          ctl_s;
  logic [DW-1:0] din_s;
  logic          stb_fall;
  logic          stb_rise;
  logic          ctl_tog;
  sync_mode_e    act_mode;
  dir_e          act_dir;
  logic          act_tx;
  logic          act_ctl;
  logic          idle_w;
  logic          cap_evt;
  logic          adv_evt;
  logic          slot_full;

  pport_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_stb (
    .clk(clk), .rst_n(rst_n), .d(port_stb_n), .q(stb_s));
  pport_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d(port_ctl), .q(ctl_s));
  pport_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .d(port_data_in), .q(din_s));

  pport_edge #(.KIND(EDGE_FALL), .RST_VAL(1'b1)) u_edge_fall (
    .clk(clk), .rst_n(rst_n), .sig(stb_s), .evt(stb_fall));
  pport_edge #(.KIND(EDGE_RISE), .RST_VAL(1'b1)) u_edge_rise (
    .clk(clk), .rst_n(rst_n), .sig(stb_s), .evt(stb_rise));
  pport_edge #(.KIND(EDGE_ANY), .RST_VAL(1'b0)) u_edge_ctl (
    .clk(clk), .rst_n(rst_n), .sig(ctl_s), .evt(ctl_tog));

  // configuration is taken over only while nothing is in flight
  assign idle_w = !rx_valid && !slot_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_mode <= SYNC_STROBE;
      act_dir  <= DIR_RX;
    end else if (idle_w) begin
      act_mode <= sync_mode_e'(cfg_ctl_clk);
      act_dir  <= dir_e'(cfg_tx);
    end
  end

  assign act_tx  = (act_dir == DIR_TX);
  assign act_ctl = (act_mode == SYNC_CTLCLK);

  assign cap_evt = !act_tx && sel_event(act_mode, stb_fall, ctl_tog);
  assign adv_evt = act_tx && sel_event(act_mode, stb_rise, ctl_tog);

  pport_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .cap(cap_evt), .din(din_s), .rx_ready(rx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .overflow(rx_overflow));

  pport_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(act_tx), .adv(adv_evt), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .pins(port_data_out), .slot_full(slot_full));

  assign port_data_oe = act_tx;
endmodule

// File: rtl/pport_endpoint_chk.sv
`timescale 1ns/1ps
module pport_endpoint_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [DW-1:0] rx_data,
  input logic          rx_overflow,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [DW-1:0] tx_data,
  input logic [DW-1:0] port_data_out,
  input logic          port_data_oe,
  input logic          act_tx,
  input logic          act_ctl,
  input logic          idle_w,
  input logic          cap_evt,
  input logic          adv_evt,
  input logic          slot_full
);
  // R5
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R5
  overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |-> $past(cap_evt && rx_valid && !rx_ready));

  // R2
  rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> rx_valid);

  // R11
  tx_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (port_data_out == $past(tx_data)));

  // R8
  tx_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> port_data_oe);

  // R6
  tx_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && slot_full) |-> adv_evt);

  // R9
  cfg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_tx != $past(act_tx)) || (act_ctl != $past(act_ctl))) |-> $past(idle_w));
endmodule

bind pport_endpoint pport_endpoint_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .rx_overflow(rx_overflow), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .port_data_out(port_data_out),
  .port_data_oe(port_data_oe), .act_tx(act_tx), .act_ctl(act_ctl),
  .idle_w(idle_w), .cap_evt(cap_evt), .adv_evt(adv_evt), .slot_full(slot_full));

// File: tb/pport_endpoint_tb.sv
`timescale 1ns/1ps
module pport_endpoint_tb;
  localparam int E = 70;   // one host E cycle in system clocks
  localparam int H = 35;   // half E cycle

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_ctl_clk = 1'b0;
  logic cfg_tx = 1'b0;
  logic stb_n = 1'b1;
  logic ctl = 1'b0;
  logic [7:0] pin_d = 8'h00;
  logic rx_ready = 1'b1;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  wire [7:0] pout;
  wire oe;
  wire rx_valid;
  wire [7:0] rx_data;
  wire rx_overflow;
  wire tx_ready;

  int n_chk = 0;
  int n_bad = 0;
  int ovf_cnt = 0;
  string cur_req = "R2";
  logic [7:0] rx_exp [$];
  logic [7:0] src_q [$];
  logic [7:0] tx_exp [$];

  always #10 clk = ~clk;

  pport_endpoint u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_ctl_clk(cfg_ctl_clk), .cfg_tx(cfg_tx),
    .port_stb_n(stb_n), .port_ctl(ctl), .port_data_in(pin_d),
    .port_data_out(pout), .port_data_oe(oe), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .rx_overflow(rx_overflow),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // receive scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (rx_valid && rx_ready) begin
          if (rx_exp.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL %s unexpected byte actual=%0h expected=none", cur_req, rx_data);
          end else begin
            check(cur_req, 32'(rx_data), 32'(rx_exp.pop_front()));
          end
        end
        if (rx_overflow) ovf_cnt++;
      end
    end
  end

  // transmit source: offers queued bytes; R11 taken byte is on the pins next clock
  initial begin
    logic pend;
    logic [7:0] pend_b;
    pend = 1'b0;
    pend_b = 8'h00;
    forever begin
      @(negedge clk);
      if (pend) begin
        check("R11", 32'(pout), 32'(pend_b));
        pend = 1'b0;
      end
      tx_valid = (src_q.size() > 0);
      tx_data = (src_q.size() > 0) ? src_q[0] : 8'h00;
      #5;
      if (tx_valid && tx_ready) begin
        pend_b = src_q.pop_front();
        pend = 1'b1;
      end
    end
  end

  // host write, strobe spacing of 3 E cycles
  task automatic host_wr_stb(input logic [7:0] b, input bit keep);
    wclk(H); pin_d = b; if (keep) rx_exp.push_back(b);
    wclk(E); stb_n = 1'b1;
    wclk(E); stb_n = 1'b0;
    wclk(H);
  endtask

  task automatic host_end_stb();
    wclk(E + H); stb_n = 1'b1;
    wclk(E);
  endtask

  // host write clocked by control line, strobes still pulsing
  task automatic host_wr_ctl(input logic [7:0] b);
    wclk(H); pin_d = b; rx_exp.push_back(b);
    wclk(E); stb_n = 1'b1;
    wclk(H); ctl = ~ctl;
    wclk(H); stb_n = 1'b0;
    wclk(H);
  endtask

  task automatic host_rd_stb(input bit dummy);
    if (!dummy) check("R6", 32'(pout), 32'(tx_exp.pop_front()));
    wclk(E + H); stb_n = 1'b1;
    wclk(E); stb_n = 1'b0;
    wclk(H);
  endtask

  task automatic host_rd_ctl();
    check("R7", 32'(pout), 32'(tx_exp.pop_front()));
    wclk(2 * E + H); ctl = ~ctl;
    wclk(H);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    int base;
    wclk(5);
    // R1 reset state
    check("R1", 32'(rx_valid), 0);
    check("R1", 32'(rx_overflow), 0);
    check("R1", 32'(tx_ready), 0);
    check("R1", 32'(oe), 0);
    rst_n = 1'b1;
    wclk(2);
    check("R1", 32'(rx_valid), 0);
    check("R1", 32'(oe), 0);
    wclk(5);

    // R2 strobe receive burst
    cur_req = "R2";
    host_wr_stb(8'h55, 1); host_wr_stb(8'hAA, 1); host_wr_stb(8'h00, 1);
    host_wr_stb(8'hFF, 1); host_wr_stb(8'h3C, 1); host_wr_stb(8'hC3, 1);
    host_end_stb();
    wclk(20);
    check("R2", 32'(rx_exp.size()), 0);
    check("R8", 32'(oe), 0);

    // R3 data change and no falling edge
    cur_req = "R3";
    pin_d = 8'h77; wclk(E);
    check("R3", 32'(rx_valid), 0);

    // R4 control-line receive, strobe ignored
    cur_req = "R4";
    cfg_ctl_clk = 1'b1; wclk(10);
    host_wr_ctl(8'h12); host_wr_ctl(8'h34); host_wr_ctl(8'h56);
    host_wr_ctl(8'h78); host_wr_ctl(8'h9A);
    host_end_stb();
    pin_d = 8'h99; wclk(H); stb_n = 1'b0; wclk(E); stb_n = 1'b1; wclk(E);
    check("R4", 32'(rx_exp.size()), 0);
    check("R4", 32'(rx_valid), 0);

    // R5 overflow drops the second byte
    cur_req = "R5";
    cfg_ctl_clk = 1'b0; wclk(10);
    rx_ready = 1'b0;
    base = ovf_cnt;
    host_wr_stb(8'h11, 1); host_wr_stb(8'h22, 0);
    host_end_stb();
    check("R5", 32'(ovf_cnt - base), 1);
    check("R5", 32'(rx_valid), 1);
    check("R5", 32'(rx_data), 32'h11);
    rx_ready = 1'b1; wclk(5);
    check("R5", 32'(rx_exp.size()), 0);

    // R5 capture in the same clock as the held byte leaves
    rx_ready = 1'b0;
    base = ovf_cnt;
    host_wr_stb(8'h5A, 1); host_end_stb();
    pin_d = 8'hA5; rx_exp.push_back(8'hA5);
    wclk(E);
    stb_n = 1'b0;          // pin change before rising edge P1
    wclk(1);               // between P1 and P2
    wclk(1); rx_ready = 1'b1;  // covers P3, the capture edge
    wclk(1); rx_ready = 1'b0;
    wclk(5);
    check("R5", 32'(rx_valid), 1);
    check("R5", 32'(rx_data), 32'hA5);
    check("R5", 32'(ovf_cnt - base), 0);
    rx_ready = 1'b1; wclk(5);
    stb_n = 1'b1; wclk(E);
    check("R5", 32'(rx_exp.size()), 0);

    // R9 direction change waits for idle
    cur_req = "R9";
    rx_ready = 1'b0;
    host_wr_stb(8'h81, 1); host_end_stb();
    cfg_tx = 1'b1; wclk(10);
    check("R9", 32'(oe), 0);
    rx_ready = 1'b1; wclk(5);
    check("R9", 32'(oe), 1);
    check("R8", 32'(oe), 1);

    // R6 strobe transmit with dummy read
    cur_req = "R8";
    src_q.push_back(8'hA1); src_q.push_back(8'hA2);
    src_q.push_back(8'hA3); src_q.push_back(8'hA4);
    tx_exp.push_back(8'hA1); tx_exp.push_back(8'hA2);
    tx_exp.push_back(8'hA3); tx_exp.push_back(8'hA4);
    wclk(10);
    check("R6", 32'(src_q.size()), 3);
    host_rd_stb(1);
    for (int i = 0; i < 4; i++) host_rd_stb(0);
    host_end_stb();
    check("R10", 32'(pout), 32'hA4);
    check("R10", 32'(tx_ready), 0);
    check("R8", 32'(rx_valid), 0);

    // R7 control-line transmit
    cfg_ctl_clk = 1'b1; wclk(5);
    src_q.push_back(8'hB1); src_q.push_back(8'hB2);
    src_q.push_back(8'hB3); src_q.push_back(8'hB4);
    tx_exp.push_back(8'hB1); tx_exp.push_back(8'hB2);
    tx_exp.push_back(8'hB3); tx_exp.push_back(8'hB4);
    wclk(10);
    for (int i = 0; i < 4; i++) host_rd_ctl();
    wclk(E);
    check("R10", 32'(pout), 32'hB4);
    src_q.push_back(8'hB5); tx_exp.push_back(8'hB5);
    wclk(10);
    check("R10", 32'(pout), 32'hB5);
    check("R10", 32'(src_q.size()), 0);
    host_rd_ctl();
    wclk(10);
    check("R8", 32'(rx_valid), 0);

    cfg_tx = 1'b0; wclk(10);
    check("R8", 32'(oe), 0);
    wclk(10);
    summary();
    $finish;
  end
endmodule